// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block keeps wall-clock time and a calendar in packed BCD. Its counting runs from hundredths of a second up through seconds, minutes, hours, day of week, date, month and a two-digit year. The surrounding logic supplies a one-cycle enable at 100 Hz. A bulk load writes all eight 8-bit registers at once. All eight registers are always visible on a 64-bit read bus, so a caller can take a coherent snapshot in any cycle.

The hours register changes its encoding at run time. It can count 00 to 23, or it can count 12, 1, ..., 11 with an afternoon flag. The day-of-week register also carries two control flags. One halts timekeeping. The other is a reset-enable flag that is stored and read back for the serial front end that uses it. Month lengths are derived from the month and year, and every year divisible by four is treated as a leap year. Register bits that have no meaning are discarded when a load arrives, so they always read zero.

Top module: `bcd_calendar_core`

## Requirements
- R1: Register 0 (bus bits 7:0) holds hundredths 00..99 in packed BCD. It advances by one on each cycle in which `tick` is 1, halt is 0 and `load` is 0.
- R2: Hundredths wrap 99→00 and carry into seconds (bits 15:8). Seconds wrap 59→00 and carry into minutes (bits 23:16). Minutes wrap 59→00 and carry into hours (bits 31:24).
- R3: When hours bit 7 is 0, hours count 00..23 in BCD in bits 5:0, so bit 5 is the tens-of-twenty digit. The step from 23 goes to 00 and advances the day.
- R4: When hours bit 7 is 1, bits 4:0 hold 12, 01..11 in BCD and bit 5 is PM (1 = PM). The step from 11 goes to 12 and toggles PM. The step from 12 goes to 01. The step from 11 PM to 12 AM advances the day.
- R5: Day of week sits in bits 2:0 of register 4 (bus bits 34:32). It counts 1..7, returns to 1 after 7, and advances once per day.
- R6: Date (register 5) returns to 01 after the last day of the month, which is 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 for month 02, or 29 when year mod 4 is 0. Month (register 6) counts 01..12 and returns to 01, incrementing year (register 7), which wraps 99→00.
- R7: Register 4 bit 5 is halt. While it is 1 no register changes on a tick. When it is 0, timekeeping runs.
- R8: After reset the bus reads, from register 7 down to register 0: 00, 01, 01, 0x30 | 1 (halt = 1, reset-enable = 1, day 1), 00, 00, 00, 00.
- R9: Bits that always read zero: register 1 bit 7, register 2 bit 7, register 3 bit 6, register 4 bits 7, 6 and 3, register 5 bits 7:6, and register 6 bits 7:5. Load data in these bits is discarded.
- R10: When `load` and `tick` are both 1 in a cycle, the loaded values appear unchanged and the tick is lost.
- R11: A load replaces all eight registers in one cycle, including the halt and reset-enable flags (register 4 bits 5 and 4). The new values are readable in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle 100 Hz count enable |
| load | input | 1 | Bulk load strobe |
| load_data | input | 64 | Register k is taken from bits 8k+7:8k |
| regs | output | 64 | Register k is presented on bits 8k+7:8k |

## Verification
A behavioural calendar model is compared with the bus on every clock. The bench first runs a long stretch of plain counting from a loaded time, which separates the hundredths, seconds and minutes carries. It then places the clock one hundredth before midnight on a set of end-of-month dates: a non-leap February, a leap February 28 and 29, a 30-day month and New Year's Eve of year 99. These cases separate each month length and the year wrap. One hundredth before 11 AM, 11 PM and 12 o'clock in 12-hour mode separates the PM toggle from the day carry. Loads that set the zero bits, loads that coincide with a tick, and ticks while halted cover masking, priority and freezing.

// File: rtl/bcdclk_pkg.sv
// Package: shared BCD helpers and register masks for the calendar clock.
// Assumes every operand is valid packed BCD.
package bcdclk_pkg;

    localparam int NREG  = 8;
    localparam int RBITS = 8;

    // Keep-mask for each register; zero bits always read zero.
    function automatic logic [RBITS-1:0] reg_mask(input int idx);
        case (idx)
            1, 2:    return 8'h7F;
            3:       return 8'hBF;
            4:       return 8'h37;
            5:       return 8'h3F;
            6:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // Increment a two-digit packed BCD value (no wrap handling).
    function automatic logic [RBITS-1:0] bcd_inc(input logic [RBITS-1:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year divisible by four, from its two BCD digits.
    function automatic logic bcd_leap(input logic [RBITS-1:0] yr);
        if (yr[4])
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    // Last date of a month, in BCD.
    function automatic logic [RBITS-1:0] month_last(input logic [RBITS-1:0] mon,
                                                    input logic [RBITS-1:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_wrap_counter.sv
// Module: two-digit BCD counter with a run-time upper limit.
// On a step at or above the limit it returns to MINV and flags a wrap.
// Assumes loaded values are valid BCD; a load wins over a step.
module bcd_wrap_counter
    import bcdclk_pkg::*;
#(
    parameter logic [7:0] MINV = 8'h00,
    parameter logic [7:0] RSTV = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       load,
    input  logic [7:0] ld_val,
    input  logic [7:0] maxv,
    output logic [7:0] val,
    output logic       wrap
);

    logic at_top;
    assign at_top = (val >= maxv);
    assign wrap   = step && at_top;

    // Count state: reset, load, or advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= RSTV;
        else if (load)
            val <= ld_val;
        else if (step)
            val <= at_top ? MINV : bcd_inc(val);
    end

    // R2: a step at the limit lands on the minimum value.
    p_wrap_to_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && at_top) |=> (val == MINV));

    // R7: with no step and no load the value holds.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(val));

endmodule

// File: rtl/cal_hour_ctr.sv
// Module: hours register with run-time 12/24-hour encoding.
// Bit 7 picks 12-hour mode, bit 5 is PM there, bit 6 is always zero.
// Assumes loads carry valid BCD for the selected mode.
module cal_hour_ctr
    import bcdclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       load,
    input  logic [7:0] ld_val,
    output logic [7:0] hours,
    output logic       wrap
);

    logic       mode12, pm;
    logic [7:0] h12, h24, nxt;
    logic       top;

    assign mode12 = hours[7];
    assign pm     = hours[5];
    assign h12    = {3'b000, hours[4:0]};
    assign h24    = {2'b00, hours[5:0]};

    // Next hour value and day-wrap condition for the active mode.
    always_comb begin
        top = 1'b0;
        nxt = hours;
        if (mode12) begin
            if (h12 == 8'h12) begin
                nxt = {1'b1, 1'b0, pm, 5'h01};
            end else if (h12 == 8'h11) begin
                nxt = {1'b1, 1'b0, ~pm, 5'h12};
                top = pm;
            end else begin
                nxt = {1'b1, 1'b0, pm, bcd_inc(h12)[4:0]};
            end
        end else begin
            if (h24 >= 8'h23) begin
                nxt = 8'h00;
                top = 1'b1;
            end else begin
                nxt = bcd_inc(h24);
            end
        end
    end

    assign wrap = step && top;

    // Hours state: reset, masked load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hours <= 8'h00;
        else if (load)
            hours <= ld_val & reg_mask(3);
        else if (step)
            hours <= nxt;
    end

    // R4: stepping from 11 in 12-hour mode flips the PM flag.
    p_pm_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode12 && h12 == 8'h11) |=> (hours[5] != $past(hours[5])));

    // R3: in 24-hour mode a step from 23 gives midnight.
    p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !mode12 && h24 == 8'h23) |=> (hours == 8'h00));

endmodule

// File: rtl/bcd_calendar_core.sv
// Module: BCD time-of-day and calendar core with bulk load and read.
// Advances on a 100 Hz enable unless halted; a load overrides a tick.
// Assumes the enable is a single-cycle pulse and loads carry valid BCD.
module bcd_calendar_core
    import bcdclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        load,
    input  logic [63:0] load_data,
    output logic [63:0] regs
);

    localparam int BUSW = NREG * RBITS;

    // Full-bus mask built from the per-register masks.
    function automatic logic [BUSW-1:0] bus_mask();
        logic [BUSW-1:0] m;
        for (int i = 0; i < NREG; i++)
            m[i*RBITS +: RBITS] = reg_mask(i);
        return m;
    endfunction
    localparam logic [BUSW-1:0] BUS_MASK = bus_mask();

    logic [RBITS-1:0] ld_b [NREG];
    logic [RBITS-1:0] cur  [NREG];
    logic [RBITS-1:0] dow;
    logic             halt, rst_en;
    logic             run;
    logic             w_hs, w_sec, w_min, w_hr, w_dow, w_date, w_mon, w_yr;

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_bus
            assign ld_b[gi] = load_data[gi*RBITS +: RBITS] & reg_mask(gi);
            assign regs[gi*RBITS +: RBITS] = cur[gi];
        end
    endgenerate

    assign run    = tick && !halt && !load;
    assign cur[4] = {2'b00, halt, rst_en, 1'b0, dow[2:0]};

    bcd_wrap_counter #(.MINV(8'h00), .RSTV(8'h00)) u_hund (
        .clk(clk), .rst_n(rst_n), .step(run), .load(load), .ld_val(ld_b[0]),
        .maxv(8'h99), .val(cur[0]), .wrap(w_hs));

    bcd_wrap_counter #(.MINV(8'h00), .RSTV(8'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .step(w_hs), .load(load), .ld_val(ld_b[1]),
        .maxv(8'h59), .val(cur[1]), .wrap(w_sec));

    bcd_wrap_counter #(.MINV(8'h00), .RSTV(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .step(w_sec), .load(load), .ld_val(ld_b[2]),
        .maxv(8'h59), .val(cur[2]), .wrap(w_min));

    cal_hour_ctr u_hour (
        .clk(clk), .rst_n(rst_n), .step(w_min), .load(load), .ld_val(load_data[31:24]),
        .hours(cur[3]), .wrap(w_hr));

    bcd_wrap_counter #(.MINV(8'h01), .RSTV(8'h01)) u_dow (
        .clk(clk), .rst_n(rst_n), .step(w_hr), .load(load), .ld_val({5'b0, ld_b[4][2:0]}),
        .maxv(8'h07), .val(dow), .wrap(w_dow));

    bcd_wrap_counter #(.MINV(8'h01), .RSTV(8'h01)) u_date (
        .clk(clk), .rst_n(rst_n), .step(w_hr), .load(load), .ld_val(ld_b[5]),
        .maxv(month_last(cur[6], cur[7])), .val(cur[5]), .wrap(w_date));

    bcd_wrap_counter #(.MINV(8'h01), .RSTV(8'h01)) u_mon (
        .clk(clk), .rst_n(rst_n), .step(w_date), .load(load), .ld_val(ld_b[6]),
        .maxv(8'h12), .val(cur[6]), .wrap(w_mon));

    bcd_wrap_counter #(.MINV(8'h00), .RSTV(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .step(w_mon), .load(load), .ld_val(ld_b[7]),
        .maxv(8'h99), .val(cur[7]), .wrap(w_yr));

    // Control flags held in the day register; both set by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt   <= 1'b1;
            rst_en <= 1'b1;
        end else if (load) begin
            halt   <= load_data[37];
            rst_en <= load_data[36];
        end
    end

    // R7: while halted and not loading, the whole bus holds.
    p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> $stable(regs));

    // R9: zero bits never hold a one.
    p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs & ~BUS_MASK) == '0));

    // R10 R11: a load shows its masked data one cycle later, tick or not.
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (regs == ($past(load_data) & BUS_MASK)));

    // R5: the day of week stays within 1..7 once counting from reset.
    p_dow_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dow >= 8'h01 && dow <= 8'h07) |=> (dow >= 8'h01 && dow <= 8'h07));

endmodule

// File: tb/tb_bcd_calendar_core.sv
// Bench: behavioural calendar model compared on every clock, plus directed checks.
module tb_bcd_calendar_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [63:0] load_data = '0;
    logic [63:0] regs;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // Model state as plain integers.
    int m_hs, m_sec, m_min, m_hr, m_m12, m_pm, m_dow, m_date, m_mon, m_yr, m_halt, m_rsten;

    always #5 clk = ~clk;

    bcd_calendar_core dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_data(load_data), .regs(regs));

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_of(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] model_bus();
        logic [7:0] h;
        if (m_m12 != 0) h = 8'h80 | (m_pm != 0 ? 8'h20 : 8'h00) | i2b(m_hr);
        else            h = i2b(m_hr);
        return {i2b(m_yr), i2b(m_mon), i2b(m_date),
                2'b00, 1'(m_halt), 1'(m_rsten), 1'b0, 3'(m_dow),
                h, i2b(m_min), i2b(m_sec), i2b(m_hs)};
    endfunction

    task automatic model_day();
        m_dow  = (m_dow == 7) ? 1 : m_dow + 1;
        m_date = m_date + 1;
        if (m_date > days_of(m_mon, m_yr)) begin
            m_date = 1;
            m_mon  = m_mon + 1;
            if (m_mon > 12) begin
                m_mon = 1;
                m_yr  = (m_yr + 1) % 100;
            end
        end
    endtask

    task automatic model_hour();
        if (m_m12 != 0) begin
            if (m_hr == 12) m_hr = 1;
            else if (m_hr == 11) begin
                m_hr = 12;
                m_pm = 1 - m_pm;
                if (m_pm == 0) model_day();
            end else m_hr = m_hr + 1;
        end else begin
            m_hr = (m_hr + 1) % 24;
            if (m_hr == 0) model_day();
        end
    endtask

    // Reference model update at each active edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hs = 0; m_sec = 0; m_min = 0; m_hr = 0; m_m12 = 0; m_pm = 0;
            m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0; m_halt = 1; m_rsten = 1;
        end else if (load) begin
            m_hs   = b2i(load_data[7:0]);
            m_sec  = b2i(load_data[15:8] & 8'h7F);
            m_min  = b2i(load_data[23:16] & 8'h7F);
            m_m12  = int'(load_data[31]);
            if (m_m12 != 0) begin
                m_pm = int'(load_data[29]);
                m_hr = b2i({3'b000, load_data[28:24]});
            end else begin
                m_pm = 0;
                m_hr = b2i({2'b00, load_data[29:24]});
            end
            m_dow   = int'(load_data[34:32]);
            m_rsten = int'(load_data[36]);
            m_halt  = int'(load_data[37]);
            m_date  = b2i(load_data[47:40] & 8'h3F);
            m_mon   = b2i(load_data[55:48] & 8'h1F);
            m_yr    = b2i(load_data[63:56]);
        end else if (tick && m_halt == 0) begin
            m_hs = m_hs + 1;
            if (m_hs == 100) begin
                m_hs = 0; m_sec = m_sec + 1;
                if (m_sec == 60) begin
                    m_sec = 0; m_min = m_min + 1;
                    if (m_min == 60) begin
                        m_min = 0;
                        model_hour();
                    end
                end
            end
        end
    end

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R1";
            1, 2:    return "R2";
            3:       return "R3 R4";
            4:       return "R5 R7";
            default: return "R6";
        endcase
    endfunction

    // Per-cycle comparison of the bus with the model.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [63:0] exp_bus;
            logic        miss;
            exp_bus = model_bus();
            miss = 1'b0;
            total++;
            for (int i = 0; i < 8; i++) begin
                if (regs[i*8 +: 8] !== exp_bus[i*8 +: 8]) begin
                    $display("FAIL %s reg%0d actual=%h expected=%h", tag_of(i), i,
                             regs[i*8 +: 8], exp_bus[i*8 +: 8]);
                    miss = 1'b1;
                end
            end
            if (miss) bad++;
        end
    end

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check_bus(input logic [63:0] exp, input string tag);
        total++;
        if (regs !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, regs, exp);
        end
    endtask

    task automatic check_byte(input int idx, input logic [7:0] exp, input string tag);
        total++;
        if (regs[idx*8 +: 8] !== exp) begin
            bad++;
            $display("FAIL %s reg%0d actual=%h expected=%h", tag, idx, regs[idx*8 +: 8], exp);
        end
    endtask

    // Load all registers; caller is at a falling edge.
    task automatic do_load(input logic [63:0] d, input logic with_tick);
        load = 1'b1; tick = with_tick; load_data = d;
        @(negedge clk);
        load = 1'b0; tick = 1'b0;
    endtask

    task automatic run(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset values.
        check_bus(64'h00_01_01_31_00_00_00_00, "R8 reset");
        // R7: halted from reset, ticks change nothing.
        run(5);
        check_bus(64'h00_01_01_31_00_00_00_00, "R7 halted after reset");

        // R10 R11: load with coinciding tick, non-leap February end.
        do_load(64'h23_02_28_07_23_59_59_99, 1'b1);
        check_bus(64'h23_02_28_07_23_59_59_99, "R10 R11 load wins");
        run(1);
        check_bus(64'h23_03_01_01_00_00_00_00, "R3 R5 R6 feb non-leap");

        // R6: leap February 28 then 29.
        do_load(64'h24_02_28_03_23_59_59_99, 1'b0);
        run(1);
        check_byte(5, 8'h29, "R6 leap feb28");
        do_load(64'h24_02_29_03_23_59_59_99, 1'b0);
        run(1);
        check_bus(64'h24_03_01_04_00_00_00_00, "R6 leap feb29");

        // R6: thirty-day month and year wrap.
        do_load(64'h25_04_30_02_23_59_59_99, 1'b0);
        run(1);
        check_bus(64'h25_05_01_03_00_00_00_00, "R6 april end");
        do_load(64'h99_12_31_05_23_59_59_99, 1'b0);
        run(1);
        check_bus(64'h00_01_01_06_00_00_00_00, "R6 year wrap");

        // R4: 12-hour mode transitions.
        do_load(64'h10_06_15_02_91_59_59_99, 1'b0);
        run(1);
        check_byte(3, 8'hB2, "R4 11AM to 12PM");
        check_byte(5, 8'h15, "R4 no day at noon");
        do_load(64'h10_06_15_02_B1_59_59_99, 1'b0);
        run(1);
        check_byte(3, 8'h92, "R4 11PM to 12AM");
        check_byte(5, 8'h16, "R4 day at midnight");
        do_load(64'h10_06_15_02_92_59_59_99, 1'b0);
        run(1);
        check_byte(3, 8'h81, "R4 12 to 1");

        // R9: zero bits discarded on load.
        do_load(64'h45_E7_D5_CB_52_B3_C5_10, 1'b0);
        check_bus(64'h45_07_15_03_12_33_45_10, "R9 masked load");

        // R7: halt set by load freezes everything.
        do_load(64'h30_07_04_21_08_00_00_00, 1'b0);
        run(20);
        check_bus(64'h30_07_04_21_08_00_00_00, "R7 halt freeze");

        // R1 R2: resume and count through seconds and a minute.
        do_load(64'h30_07_04_01_08_00_00_00, 1'b0);
        run(250);
        check_byte(0, 8'h50, "R1 hundredths");
        check_byte(1, 8'h02, "R2 seconds");
        run(6000);
        check_byte(2, 8'h01, "R2 minutes");
        check_byte(1, 8'h02, "R2 seconds after minute");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule